// File: doc/BRIEF.md
# I2C Master Bus-Clear Sequencer

This block sits beside the byte engine of an I2C master and frees a bus on which a slave keeps SDA low. While idle it watches the synchronized SDA input. It starts a recovery in two cases: SDA reads low for longer than a programmed window, or software gives a request strobe. During a recovery it toggles only the SCL open-drain drive-enable, with each half-period set by a divider value. After every clock pulse it checks whether SDA has been let go.

When SDA reads high the sequencer stops pulsing and puts a STOP condition on the bus. It then reports success with a one-cycle done strobe and the number of pulses it used. If SDA is still low after the last allowed pulse, the block reports failure instead and raises a request for a hardware reset or power cycle of the slave. That request stays up until the line recovers or a new recovery is started.

Top module: `busclr_seq`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, done, ok, hard_rst_req and stuck are all 0 and pulses is 0.
- R2: A start strobe while idle with SDA low begins pulsing with an SCL low phase (scl_oe=1). Each low phase and each high phase lasts div_val+1 clock cycles, and sda_oe stays 0 throughout the pulses.
- R3: SDA is sampled at the end of each SCL high phase, and the count of completed pulses is kept. The first sample that reads high ends the pulsing, and pulses then reports that count.
- R4: After SDA is released, a STOP is produced. First SCL is held low for one phase. Then sda_oe rises while scl_oe is 1, then scl_oe falls while sda_oe is 1, and finally sda_oe falls while scl_oe is 0. At that point done pulses for one cycle with ok=1.
- R5: If SDA is still low after MAX_PULSES (default 9) pulses, the sequence ends with done=1, ok=0, pulses=MAX_PULSES and hard_rst_req=1, and sda_oe is never driven.
- R6: hard_rst_req stays 1 while SDA reads low in idle, and no automatic recovery starts during that time. It clears once SDA reads high or a new start is accepted.
- R7: Automatic detection starts a recovery and sets stuck=1 in the cycle after SDA has read low for win_limit+1 consecutive idle cycles. A low run of only win_limit cycles starts nothing.
- R8: With win_limit=0, automatic detection is off and stuck stays 0.
- R9: A start while SDA already reads high skips the pulses and goes straight to the STOP sequence. It reports pulses=0 and ok=1, with exactly one SCL rising edge.
- R10: A start strobe while busy is ignored, and the sequence in progress finishes with its own pulse count.
- R11: stuck clears when a recovery completes successfully, and done is high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Synchronized SDA line level |
| div_val | input | DIV_W | Phase length minus one, in clock cycles |
| win_limit | input | WIN_W | Low-time limit for automatic detection; 0 disables it |
| start | input | 1 | Recovery request strobe |
| scl_oe | output | 1 | SCL drive-enable (1 pulls the line low) |
| sda_oe | output | 1 | SDA drive-enable (1 pulls the line low) |
| busy | output | 1 | Recovery sequence in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| ok | output | 1 | Last sequence freed the bus |
| pulses | output | PULSE_W | SCL pulses used by the last sequence |
| hard_rst_req | output | 1 | Request for a slave hardware reset or power cycle |
| stuck | output | 1 | Automatic detection found SDA held low |

## Verification
A modelled slave holds SDA low and lets go after a chosen number of SCL rising edges: one, three or four edges, or never. These cases separate early termination from the full nine-pulse failure, and the phase lengths are measured at two divider settings. SDA low runs of exactly the window length and of one cycle more set apart the detection threshold. A disabled window and a run during a pending reset request show that automatic starts are suppressed. A start with SDA already high, and a second start given in mid-sequence, separate the STOP-only path and the ignore rule from normal pulsing.

// File: rtl/busclr_pkg.sv
package busclr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CLK_LO,
        S_CLK_HI,
        S_STP_PRE,
        S_STP_SDA,
        S_STP_REL
    } bc_state_e;
endpackage

// File: rtl/busclr_phase.sv
module busclr_phase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             end_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign end_o = run && (cnt_q >= div_val);

    always_comb begin
        if (!run || end_o) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a phase never outlasts the divider while the divider is held
    a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(div_val)) |-> (cnt_q <= div_val));
endmodule

// File: rtl/busclr_watch.sv
module busclr_watch #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sda_in,
    input  logic [WIN_W-1:0] win_limit,
    output logic             hit_o
);
    logic [WIN_W-1:0] cnt_d, cnt_q;
    logic             active;

    assign active = arm && !sda_in && (win_limit != '0);
    assign hit_o  = active && (cnt_q >= win_limit);

    always_comb begin
        if (!active)               cnt_d = '0;
        else if (cnt_q < win_limit) cnt_d = cnt_q + 1'b1;
        else                       cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: a hit needs at least one counted low cycle before it
    a_r7_hit_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(arm) && !$past(sda_in)));
endmodule

// File: rtl/busclr_seq.sv
module busclr_seq #(
    parameter int DIV_W      = 8,
    parameter int WIN_W      = 16,
    parameter int MAX_PULSES = 9,
    localparam int PULSE_W   = $clog2(MAX_PULSES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_in,
    input  logic [DIV_W-1:0]   div_val,
    input  logic [WIN_W-1:0]   win_limit,
    input  logic               start,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               busy,
    output logic               done,
    output logic               ok,
    output logic [PULSE_W-1:0] pulses,
    output logic               hard_rst_req,
    output logic               stuck
);
    import busclr_pkg::*;

    localparam logic [PULSE_W-1:0] LAST_PULSE = PULSE_W'(MAX_PULSES);

    typedef struct packed {
        bc_state_e          st;
        logic               scl;
        logic               sda;
        logic               done;
        logic               ok;
        logic               hard;
        logic               stuck;
        logic [PULSE_W-1:0] npulse;
    } seq_t;

    seq_t r_d, r_q;
    logic ph_end, hit, run, arm;
    logic [PULSE_W-1:0] next_cnt;

    assign run = (r_q.st != S_IDLE);
    assign arm = (r_q.st == S_IDLE) && !r_q.hard;

    busclr_phase #(.DIV_W(DIV_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val), .end_o(ph_end)
    );

    busclr_watch #(.WIN_W(WIN_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sda_in(sda_in),
        .win_limit(win_limit), .hit_o(hit)
    );

    assign next_cnt = r_q.npulse + 1'b1;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (r_q.hard && sda_in) r_d.hard = 1'b0;
                if (start || hit) begin
                    r_d.hard   = 1'b0;
                    r_d.ok     = 1'b0;
                    r_d.npulse = '0;
                    r_d.scl    = 1'b1;
                    if (hit) r_d.stuck = 1'b1;
                    r_d.st     = sda_in ? S_STP_PRE : S_CLK_LO;
                end
            end
            S_CLK_LO: begin
                if (ph_end) begin
                    r_d.st  = S_CLK_HI;
                    r_d.scl = 1'b0;
                end
            end
            S_CLK_HI: begin
                if (ph_end) begin
                    r_d.npulse = next_cnt;
                    if (sda_in) begin
                        r_d.st  = S_STP_PRE;
                        r_d.scl = 1'b1;
                    end else if (next_cnt >= LAST_PULSE) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                        r_d.ok   = 1'b0;
                        r_d.hard = 1'b1;
                    end else begin
                        r_d.st  = S_CLK_LO;
                        r_d.scl = 1'b1;
                    end
                end
            end
            S_STP_PRE: begin
                if (ph_end) begin
                    r_d.st  = S_STP_SDA;
                    r_d.sda = 1'b1;
                end
            end
            S_STP_SDA: begin
                if (ph_end) begin
                    r_d.st  = S_STP_REL;
                    r_d.scl = 1'b0;
                end
            end
            S_STP_REL: begin
                if (ph_end) begin
                    r_d.st    = S_IDLE;
                    r_d.sda   = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                    r_d.stuck = 1'b0;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, scl: 1'b0, sda: 1'b0, done: 1'b0, ok: 1'b0,
                     hard: 1'b0, stuck: 1'b0, npulse: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe       = r_q.scl;
    assign sda_oe       = r_q.sda;
    assign busy         = run;
    assign done         = r_q.done;
    assign ok           = r_q.ok;
    assign pulses       = r_q.npulse;
    assign hard_rst_req = r_q.hard;
    assign stuck        = r_q.stuck;

    // R2: SDA is left alone while clock pulses are produced
    a_r2_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CLK_LO || r_q.st == S_CLK_HI) |-> !sda_oe);
    // R4: SDA is pulled low only while SCL is held low
    a_r4_sda_low_under_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe);
    // R4: SDA is released only after SCL has been released
    a_r4_sda_rel_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_oe && done && ok));
    // R5: the pulse count never exceeds the maximum
    a_r5_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= LAST_PULSE);
    // R5: a reset request only comes with a failed sequence
    a_r5_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_rst_req) |-> (done && !ok && pulses == LAST_PULSE));
    // R11: done lasts a single cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/busclr_seq_bench.sv
`timescale 1ns/1ps
module busclr_seq_bench;
    localparam int DIV_W = 8;
    localparam int WIN_W = 16;
    localparam int MAXP  = 9;
    localparam int PW    = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] div_val = 8'd3;
    logic [WIN_W-1:0] win_limit = '0;
    logic start = 1'b0;
    logic scl_oe, sda_oe, busy, done, ok, hard_rst_req, stuck;
    logic [PW-1:0] pulses;
    logic sda_in;

    logic hold_req = 1'b0;
    int   rel_after = 0;
    int   base = 0;
    int   scl_rises = 0, sda_rises = 0, order_bad = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;
    logic slave_hold;

    int errors = 0, checks = 0;
    bit finished = 0;
    int cap_pulses;
    bit cap_ok, cap_hard, cap_seen;

    always #10 clk = ~clk;

    assign slave_hold = hold_req && !(rel_after != 0 && (scl_rises - base) >= rel_after);
    assign sda_in = !(sda_oe || slave_hold);

    busclr_seq #(.DIV_W(DIV_W), .WIN_W(WIN_W), .MAX_PULSES(MAXP)) u_busclr_seq (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .div_val(div_val),
        .win_limit(win_limit), .start(start), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .ok(ok), .pulses(pulses),
        .hard_rst_req(hard_rst_req), .stuck(stuck)
    );

    always @(negedge clk) begin
        if (prev_scl && !scl_oe) scl_rises <= scl_rises + 1;
        if (!prev_sda && sda_oe) begin
            sda_rises <= sda_rises + 1;
            if (!scl_oe) order_bad <= order_bad + 1;
        end
        if (prev_sda && !sda_oe && scl_oe) order_bad <= order_bad + 1;
        if (prev_sda && sda_oe && prev_scl && !scl_oe && !sda_oe) order_bad <= order_bad + 1;
        prev_scl <= scl_oe;
        prev_sda <= sda_oe;
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mark();
        @(negedge clk);
        base = scl_rises;
        sda_rises = 0;
        order_bad = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        cap_seen = 0;
        for (int i = 0; i < 2000 && !cap_seen; i++) begin
            @(negedge clk);
            if (done) begin
                cap_seen = 1;
                cap_pulses = pulses;
                cap_ok = ok;
                cap_hard = hard_rst_req;
            end
        end
        check(cap_seen, "R11 done seen", cap_seen, 1);
        @(negedge clk);
        check(!done, "R11 done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check(!scl_oe && !sda_oe && !busy && !done && !ok && !hard_rst_req && !stuck,
              "R1 outputs idle", {scl_oe, sda_oe, busy, done, ok, hard_rst_req, stuck}, 0);
        check(pulses == 0, "R1 pulses zero", pulses, 0);
    endtask

    task automatic t_release(input int k, input int dv);
        int lo, hi;
        div_val = DIV_W'(dv);
        hold_req = 1'b1;
        rel_after = k;
        mark();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(scl_oe && busy, "R2 first phase low", scl_oe, 1);
        lo = 0;
        while (scl_oe && lo < 1000) begin lo++; @(negedge clk); end
        check(lo == dv + 1, "R2 low phase length", lo, dv + 1);
        hi = 0;
        while (!scl_oe && hi < 1000) begin hi++; @(negedge clk); end
        check(hi == dv + 1, "R2 high phase length", hi, dv + 1);
        wait_done();
        check(cap_ok && !cap_hard, "R4 success flags", {cap_ok, cap_hard}, 2);
        check(cap_pulses == k, "R3 pulses used", cap_pulses, k);
        check(scl_rises - base == k + 1, "R3 scl rising edges", scl_rises - base, k + 1);
        check(sda_rises == 1 && order_bad == 0, "R4 stop order", order_bad, 0);
        hold_req = 1'b0;
    endtask

    task automatic t_never();
        div_val = 8'd1;
        hold_req = 1'b1;
        rel_after = 0;
        mark();
        pulse_start();
        wait_done();
        check(!cap_ok && cap_hard, "R5 fail flags", {cap_ok, cap_hard}, 1);
        check(cap_pulses == MAXP, "R5 pulse count", cap_pulses, MAXP);
        check(sda_rises == 0, "R5 sda not driven", sda_rises, 0);
        check(scl_rises - base == MAXP, "R5 scl rising edges", scl_rises - base, MAXP);
    endtask

    task automatic t_hard_hold();
        win_limit = 16'd4;
        repeat (40) @(negedge clk);
        check(!busy && hard_rst_req, "R6 request held, no auto start", {busy, hard_rst_req}, 1);
        hold_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!hard_rst_req, "R6 request cleared by SDA high", hard_rst_req, 0);
        win_limit = '0;
    endtask

    task automatic t_auto();
        div_val = 8'd2;
        win_limit = 16'd5;
        rel_after = 2;
        mark();
        hold_req = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy, "R7 not started after limit cycles", busy, 0);
        @(negedge clk);
        check(busy && stuck, "R7 started after limit+1", {busy, stuck}, 3);
        wait_done();
        check(cap_ok && cap_pulses == 2, "R7 auto recovery result", cap_pulses, 2);
        check(!stuck, "R11 stuck cleared", stuck, 0);
        hold_req = 1'b0;
    endtask

    task automatic t_glitch();
        win_limit = 16'd5;
        @(negedge clk);
        hold_req = 1'b1;
        rel_after = 0;
        repeat (5) @(negedge clk);
        hold_req = 1'b0;
        repeat (20) @(negedge clk);
        check(!busy && !stuck, "R7 short low run ignored", {busy, stuck}, 0);
    endtask

    task automatic t_disabled();
        win_limit = '0;
        @(negedge clk);
        hold_req = 1'b1;
        rel_after = 0;
        repeat (60) @(negedge clk);
        check(!busy && !stuck, "R8 detection disabled", {busy, stuck}, 0);
        hold_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sda_high();
        div_val = 8'd3;
        hold_req = 1'b0;
        mark();
        pulse_start();
        wait_done();
        check(cap_ok && cap_pulses == 0, "R9 stop only", cap_pulses, 0);
        check(scl_rises - base == 1, "R9 one scl rise", scl_rises - base, 1);
        check(order_bad == 0 && sda_rises == 1, "R9 stop order", order_bad, 0);
    endtask

    task automatic t_busy_start();
        div_val = 8'd2;
        hold_req = 1'b1;
        rel_after = 4;
        mark();
        pulse_start();
        for (int i = 0; i < 500 && (scl_rises - base) < 2; i++) @(negedge clk);
        pulse_start();
        wait_done();
        check(cap_ok && cap_pulses == 4, "R10 start while busy ignored", cap_pulses, 4);
        hold_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_release(3, 3);
        t_release(1, 0);
        t_never();
        t_hard_hold();
        t_auto();
        t_glitch();
        t_disabled();
        t_sda_high();
        t_busy_start();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule